// File: doc/BRIEF.md
# Write Protect Register Controller

This block guards the array of a serial non-volatile memory against unwanted writes. It keeps a boundary register that holds the lowest protected address, an enable flag that switches the protection on, and a one-time lock bit. Once the lock bit is set, the boundary and the flag can no longer be changed. The instruction decoder upstream hands it one protect-related instruction per cycle, together with the current levels of two external pins: a protect-enable pin and a write-enable pin. For any write address the write path presents, the block answers combinationally whether that address is protected. It also tells the whole-array write path whether a full-array write may proceed.

The three protection state elements stand for non-volatile cells. They are set to their factory values only by a power-on initialisation input. The soft reset leaves them untouched. The soft reset clears only the volatile state: the arming from an enable instruction and the read-out port. Every modifying instruction must follow an arming instruction directly. Whatever instruction comes next uses up the arming, whether or not that instruction has any effect.

Top module: `wp_guard`

## Requirements
- R1: While `pwr_on_n` is low at a clock edge, the boundary is set to all ones, the flag and the lock are cleared, the arming is dropped and `rd_valid` goes low. A low `rst_n` drops only the arming and `rd_valid`, and keeps the boundary, the flag and the lock.
- R2: The arm instruction (`cmd_op` = 1) arms the block only when `pin_pre` and `pin_we` are both high. Any accepted instruction that follows, including a no-operation code (0, 6 or 7), removes the arming.
- R3: The clear instruction (`cmd_op` = 2) sets the boundary to all ones and clears the flag. It acts only when the block is armed, both pins are high and the lock is clear.
- R4: The load instruction (`cmd_op` = 3) copies `cmd_data` into the boundary and sets the flag. It acts under the same conditions as R3.
- R5: The lock instruction (`cmd_op` = 5) sets the lock bit under the same conditions as R3. The lock bit then stays set until power-on initialisation.
- R6: A clear, load or lock instruction leaves the boundary, the flag and the lock unchanged if any of these holds: the block is not armed, either pin is low, or the lock is set.
- R7: The read instruction (`cmd_op` = 4) needs no arming and no pins. On the following cycle, `rd_valid` is high and `rd_base`, `rd_on` and `rd_lock` show the boundary, the flag and the lock. In every other cycle `rd_valid` is low.
- R8: `chk_prot` is high exactly when the flag is set and `chk_addr` is greater than or equal to the boundary. It follows the state present in the same cycle, with no register delay.
- R9: `wrall_ok` is high exactly when the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, synchronous, active low; volatile state only |
| pwr_on_n | input | 1 | Power-on initialisation, synchronous, active low; all state |
| cmd_valid | input | 1 | An instruction is presented this cycle |
| cmd_op | input | 3 | Instruction code: 0 none, 1 arm, 2 clear, 3 load, 4 read, 5 lock |
| cmd_data | input | ADDR_W | Boundary value for the load instruction |
| pin_pre | input | 1 | Protect-enable pin level |
| pin_we | input | 1 | Write-enable pin level |
| chk_addr | input | ADDR_W | Candidate write address |
| chk_prot | output | 1 | Candidate address is protected |
| wrall_ok | output | 1 | Whole-array write permitted |
| rd_valid | output | 1 | Read-out fields valid |
| rd_base | output | ADDR_W | Boundary value read out |
| rd_on | output | 1 | Flag value read out |
| rd_lock | output | 1 | Lock value read out |

## Verification
A protection query and a change of the boundary can fall in the same cycle: the write path asks about an address while a load or clear instruction is being executed. The bench holds `chk_addr` steady while a load is applied, and samples `chk_prot` twice. The sample just before the executing edge must give the decision for the old boundary. The sample just after that edge must give the decision for the new boundary. This shows that the query sees the current state with no delay and does not take the incoming value early.

// File: rtl/wp_pkg.sv
// Shared definitions for the write protect controller.
// Assumes one instruction per cycle, decoded upstream into these codes.
package wp_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ARM   = 3'd1,
        OP_CLEAR = 3'd2,
        OP_LOAD  = 3'd3,
        OP_READ  = 3'd4,
        OP_LOCK  = 3'd5
    } wp_op_e;

    // Execution strobes produced by the gate for the state holder
    typedef struct packed {
        logic clear;
        logic load;
        logic lock;
    } wp_exec_t;

endpackage

// File: rtl/wp_gate.sv
// Arming latch and execution gate.
// A modifying instruction runs only if the arm instruction came directly before it,
// both pins are high now and the lock bit is clear. Every accepted instruction uses
// up the arming. Assumes vol_rst_n is already the AND of both reset inputs.
module wp_gate
    import wp_pkg::*;
(
    input  logic     clk,
    input  logic     vol_rst_n,
    input  logic     cmd_valid,
    input  wp_op_e   cmd_op,
    input  logic     pin_pre,
    input  logic     pin_we,
    input  logic     locked,
    output logic     armed,
    output wp_exec_t exec
);

    logic pins_ok;
    logic may_modify;

    assign pins_ok    = pin_pre && pin_we;
    assign may_modify = cmd_valid && armed && pins_ok && !locked;

    // Arming: set by an arm with both pins high, dropped by any other accepted instruction
    always_ff @(posedge clk) begin
        if (!vol_rst_n) begin
            armed <= 1'b0;
        end else if (cmd_valid) begin
            armed <= (cmd_op == OP_ARM) && pins_ok;
        end
    end

    // Execution strobes for the state holder
    always_comb begin
        exec.clear = may_modify && (cmd_op == OP_CLEAR);
        exec.load  = may_modify && (cmd_op == OP_LOAD);
        exec.lock  = may_modify && (cmd_op == OP_LOCK);
    end

endmodule

// File: rtl/wp_nvstate.sv
// Protection state standing for non-volatile cells: boundary, enable flag, lock bit.
// Only the power-on input sets factory values; the soft reset does not reach here.
// Assumes the gate raises at most one strobe per cycle.
module wp_nvstate
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              pwr_on_n,
    input  wp_exec_t          exec,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] base,
    output logic              prot_on,
    output logic              locked
);

    localparam logic [ADDR_W-1:0] BASE_TOP = {ADDR_W{1'b1}};

    // Boundary register: top of the array after factory init or clear, loaded on load
    always_ff @(posedge clk) begin
        if (!pwr_on_n) begin
            base <= BASE_TOP;
        end else if (exec.clear) begin
            base <= BASE_TOP;
        end else if (exec.load) begin
            base <= load_val;
        end
    end

    // Enable flag: cleared by clear, set by load
    always_ff @(posedge clk) begin
        if (!pwr_on_n) begin
            prot_on <= 1'b0;
        end else if (exec.clear) begin
            prot_on <= 1'b0;
        end else if (exec.load) begin
            prot_on <= 1'b1;
        end
    end

    // Lock bit: can only be set; only power-on clears it
    always_ff @(posedge clk) begin
        if (!pwr_on_n) begin
            locked <= 1'b0;
        end else if (exec.lock) begin
            locked <= 1'b1;
        end
    end

endmodule

// File: rtl/wp_cmp.sv
// Protection decision for one candidate address against the boundary.
// Purely combinational so that the write path gets the answer in the same cycle.
module wp_cmp #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              prot_on,
    output logic              hit
);

    // Address at or above the boundary is protected while the flag is on
    always_comb begin
        hit = prot_on && (addr >= base);
    end

endmodule

// File: rtl/wp_guard.sv
// Top of the write protect controller: gate, protection state, address compare
// and a registered read-out port. Assumes the decoder upstream delivers at most one
// instruction per cycle, with pin levels sampled in that same cycle.
module wp_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_data,
    input  logic              pin_pre,
    input  logic              pin_we,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_prot,
    output logic              wrall_ok,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_base,
    output logic              rd_on,
    output logic              rd_lock
);

    logic              vol_rst_n;
    wp_op_e            op;
    logic              armed;
    wp_exec_t          exec;
    logic [ADDR_W-1:0] prot_base;
    logic              prot_on;
    logic              otp_lock;

    assign vol_rst_n = rst_n && pwr_on_n;
    assign op        = wp_op_e'(cmd_op);

    wp_gate i_gate (
        .clk       (clk),
        .vol_rst_n (vol_rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (op),
        .pin_pre   (pin_pre),
        .pin_we    (pin_we),
        .locked    (otp_lock),
        .armed     (armed),
        .exec      (exec)
    );

    wp_nvstate #(.ADDR_W(ADDR_W)) i_state (
        .clk      (clk),
        .pwr_on_n (pwr_on_n),
        .exec     (exec),
        .load_val (cmd_data),
        .base     (prot_base),
        .prot_on  (prot_on),
        .locked   (otp_lock)
    );

    wp_cmp #(.ADDR_W(ADDR_W)) i_cmp (
        .addr    (chk_addr),
        .base    (prot_base),
        .prot_on (prot_on),
        .hit     (chk_prot)
    );

    // Whole-array write is open only while protection is off
    assign wrall_ok = !prot_on;

    // Read-out valid strobe: one cycle after a read instruction
    always_ff @(posedge clk) begin
        if (!vol_rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cmd_valid && (op == OP_READ);
        end
    end

    // Read-out fields: capture the state as it stands when the read is taken
    always_ff @(posedge clk) begin
        if (!vol_rst_n) begin
            rd_base <= '0;
            rd_on   <= 1'b0;
            rd_lock <= 1'b0;
        end else if (cmd_valid && (op == OP_READ)) begin
            rd_base <= prot_base;
            rd_on   <= prot_on;
            rd_lock <= otp_lock;
        end
    end

endmodule

// File: rtl/wp_guard_chk.sv
// Property checker for wp_guard, attached by bind. It observes the ports and the
// state driven by the gate and the state holder.
module wp_guard_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_on_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_data,
    input logic              pin_pre,
    input logic              pin_we,
    input logic [ADDR_W-1:0] chk_addr,
    input logic              chk_prot,
    input logic              wrall_ok,
    input logic              rd_valid,
    input logic              armed,
    input logic [ADDR_W-1:0] prot_base,
    input logic              prot_on,
    input logic              otp_lock
);

    logic go;
    assign go = cmd_valid && armed && pin_pre && pin_we && !otp_lock;

    // R2
    arm_used_up_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        (cmd_valid && cmd_op != 3'd1) |=> !armed);

    // R3
    clear_effect_chk: assert property (@(posedge clk) disable iff (!pwr_on_n)
        (go && cmd_op == 3'd2) |=> (prot_base == {ADDR_W{1'b1}} && !prot_on));

    // R4
    load_effect_chk: assert property (@(posedge clk) disable iff (!pwr_on_n)
        (go && cmd_op == 3'd3) |=> (prot_base == $past(cmd_data) && prot_on));

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_on_n)
        otp_lock |=> otp_lock);

    // R6
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (!pwr_on_n)
        (!armed || otp_lock || !pin_pre || !pin_we) |=>
            ($stable(prot_base) && $stable(prot_on) && $stable(otp_lock)));

    // R7
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        (cmd_valid && cmd_op == 3'd4) |=> rd_valid);

    // R8
    off_unprot_chk: assert property (@(posedge clk) disable iff (!pwr_on_n)
        !prot_on |-> !chk_prot);

    // R8
    at_base_prot_chk: assert property (@(posedge clk) disable iff (!pwr_on_n)
        (prot_on && chk_addr == prot_base) |-> chk_prot);

    // R9
    wrall_vs_prot_chk: assert property (@(posedge clk) disable iff (!pwr_on_n)
        wrall_ok |-> !chk_prot);

endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on_n  (pwr_on_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .pin_pre   (pin_pre),
    .pin_we    (pin_we),
    .chk_addr  (chk_addr),
    .chk_prot  (chk_prot),
    .wrall_ok  (wrall_ok),
    .rd_valid  (rd_valid),
    .armed     (armed),
    .prot_base (prot_base),
    .prot_on   (prot_on),
    .otp_lock  (otp_lock)
);

// File: tb/test_wp_guard.sv
`timescale 1ns/100ps
module test_wp_guard;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_on_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_data = '0;
    logic          pin_pre = 1'b0;
    logic          pin_we = 1'b0;
    logic [AW-1:0] chk_addr = '0;
    logic          chk_prot;
    logic          wrall_ok;
    logic          rd_valid;
    logic [AW-1:0] rd_base;
    logic          rd_on;
    logic          rd_lock;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wp_guard #(.ADDR_W(AW)) i_wp_guard (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one instruction at a falling edge; returns at the next falling edge
    task automatic cmd(input logic [2:0] op, input logic [AW-1:0] d, input logic pre, input logic we);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; pin_pre = pre; pin_we = we;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; pin_pre = 1'b0; pin_we = 1'b0;
    endtask

    task automatic expect_state(input logic [AW-1:0] b, input logic on, input logic lk, input string tag);
        cmd(3'd4, '0, 1'b0, 1'b0);
        check(rd_valid == 1'b1, {tag, " R7 rd_valid"}, rd_valid, 1);
        check(rd_base == b, {tag, " base"}, rd_base, b);
        check(rd_on == on, {tag, " flag"}, rd_on, on);
        check(rd_lock == lk, {tag, " lock"}, rd_lock, lk);
    endtask

    task automatic t_power_on;
        pwr_on_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
        pwr_on_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R7 idle rd_valid", rd_valid, 0);
        check(wrall_ok == 1'b1, "R9 wrall after init", wrall_ok, 1);
        chk_addr = 8'hFF; #0.1;
        check(chk_prot == 1'b0, "R8 flag off", chk_prot, 0);
        expect_state(8'hFF, 1'b0, 1'b0, "R1 factory");
    endtask

    task automatic t_load;
        cmd(3'd1, '0, 1'b1, 1'b1);
        cmd(3'd3, 8'h40, 1'b1, 1'b1);
        check(wrall_ok == 1'b0, "R9 wrall with flag", wrall_ok, 0);
        chk_addr = 8'h3F; #0.1;
        check(chk_prot == 1'b0, "R8 below base", chk_prot, 0);
        chk_addr = 8'h40; #0.1;
        check(chk_prot == 1'b1, "R8 at base", chk_prot, 1);
        chk_addr = 8'hFF; #0.1;
        check(chk_prot == 1'b1, "R8 top", chk_prot, 1);
        expect_state(8'h40, 1'b1, 1'b0, "R4 load");
        @(negedge clk);
        check(rd_valid == 1'b0, "R7 strobe one cycle", rd_valid, 0);
    endtask

    task automatic t_ignored;
        cmd(3'd3, 8'h10, 1'b1, 1'b1);
        expect_state(8'h40, 1'b1, 1'b0, "R6 unarmed");
        cmd(3'd1, '0, 1'b1, 1'b1);
        cmd(3'd0, '0, 1'b1, 1'b1);
        cmd(3'd3, 8'h10, 1'b1, 1'b1);
        expect_state(8'h40, 1'b1, 1'b0, "R2 consumed by none");
        cmd(3'd1, '0, 1'b0, 1'b1);
        cmd(3'd3, 8'h10, 1'b1, 1'b1);
        expect_state(8'h40, 1'b1, 1'b0, "R2 arm pre low");
        cmd(3'd1, '0, 1'b1, 1'b1);
        cmd(3'd2, '0, 1'b1, 1'b0);
        expect_state(8'h40, 1'b1, 1'b0, "R6 we low");
    endtask

    task automatic t_soft_reset;
        cmd(3'd1, '0, 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cmd(3'd3, 8'h10, 1'b1, 1'b1);
        expect_state(8'h40, 1'b1, 1'b0, "R1 soft reset");
    endtask

    task automatic t_same_cycle;
        cmd(3'd1, '0, 1'b1, 1'b1);
        chk_addr = 8'h30;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_data = 8'h20; pin_pre = 1'b1; pin_we = 1'b1;
        #0.1;
        check(chk_prot == 1'b0, "R8 old base in load cycle", chk_prot, 0);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; pin_pre = 1'b0; pin_we = 1'b0;
        check(chk_prot == 1'b1, "R8 new base after edge", chk_prot, 1);
    endtask

    task automatic t_clear;
        cmd(3'd1, '0, 1'b1, 1'b1);
        cmd(3'd2, '0, 1'b1, 1'b1);
        check(wrall_ok == 1'b1, "R9 wrall after clear", wrall_ok, 1);
        chk_addr = 8'hFF; #0.1;
        check(chk_prot == 1'b0, "R3 top unprotected", chk_prot, 0);
        expect_state(8'hFF, 1'b0, 1'b0, "R3 clear");
    endtask

    task automatic t_lock;
        cmd(3'd1, '0, 1'b1, 1'b1);
        cmd(3'd3, 8'h80, 1'b1, 1'b1);
        cmd(3'd1, '0, 1'b1, 1'b1);
        cmd(3'd5, '0, 1'b1, 1'b1);
        expect_state(8'h80, 1'b1, 1'b1, "R5 lock");
        cmd(3'd1, '0, 1'b1, 1'b1);
        cmd(3'd2, '0, 1'b1, 1'b1);
        expect_state(8'h80, 1'b1, 1'b1, "R6 locked clear");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        expect_state(8'h80, 1'b1, 1'b1, "R1 lock kept");
        @(negedge clk); pwr_on_n = 1'b0;
        @(negedge clk); pwr_on_n = 1'b1;
        expect_state(8'hFF, 1'b0, 1'b0, "R1 power-on");
    endtask

    initial begin
        t_power_on();
        t_load();
        t_ignored();
        t_soft_reset();
        t_same_cycle();
        t_clear();
        t_lock();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule